// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block makes exceptions precise in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Every instruction that enters decode carries a small fault record with it: a valid bit, a fault flag, a cause code and its own PC. The fault detectors in fetch, decode and execute report on the instruction that sits in their stage at that moment. The record moves forward one stage per clock. Nothing acts on a fault until the instruction reaches the memory stage, which is the commit point.

At commit, a recorded fault, a data-address fault reported by the memory stage, or a pending external interrupt turns the instruction into a trap. In the same cycle the controller flushes fetch, decode and execute, blocks the trapped instruction's writeback and steers fetch to a fixed handler address. On the next clock edge it latches the cause code and the trapped PC and masks interrupts. A return-from-exception that commits redirects fetch to the saved PC and unmasks interrupts again. The pipeline is assumed to advance every cycle. The surrounding core supplies the fault flags.

Top module: `exc_commit_ctrl`

## Requirements
- R1: After reset, the saved cause is 0, the saved PC is 0, interrupts are masked, the privilege flag shows kernel mode (user_mode_o = 0), and no redirect is driven.
- R2: A fault reported by fetch, decode or execute attaches to the instruction in that stage. It causes no redirect or kill until that instruction is in the memory stage.
- R3: When one instruction collects faults from several stages, the cause from the earliest stage is kept. The order is fetch, then decode, then execute, then memory.
- R4: When interrupts are enabled, any irq_i line is high and the commit stage holds a valid instruction, the trap is taken with cause 0. This holds whatever faults that instruction carries.
- R5: In a trap cycle, kill_f_o, kill_d_o, kill_e_o, wb_kill_o and redirect_o are all high and redirect_pc_o equals HANDLER_PC, all combinationally in that cycle.
- R6: At the edge that ends a trap cycle, epc_o takes the PC of the trapped instruction. In every other cycle epc_o holds its value.
- R7: Taking a trap clears int_en_o and user_mode_o at the next edge.
- R8: A return (m_eret_i with a valid commit instruction and no trap in that cycle) redirects to epc_o and kills fetch, decode and execute. It sets int_en_o and user_mode_o at the next edge. A trap in the same cycle takes priority over the return.
- R9: Instructions younger than a trap or a return are discarded. In the cycle after a flush, no redirect is possible.
- R10: The cause codes are: 0 interrupt, 1 fetch address fault, 2 illegal opcode, 3 arithmetic overflow, 4 data address fault.
- R11: While int_en_o is low, irq_i has no effect. A commit instruction without faults raises no trap, and one with faults traps with its own cause.
- R12: Fault inputs reported for an empty stage (a bubble) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid_i | input | 1 | Fetch stage holds an instruction |
| f_pc_i | input | XLEN | PC of the fetched instruction |
| f_addr_fault_i | input | 1 | Fetch address fault for the fetched instruction |
| d_illegal_i | input | 1 | Illegal opcode for the instruction in decode |
| e_overflow_i | input | 1 | Overflow for the instruction in execute |
| m_addr_fault_i | input | 1 | Data address fault for the instruction in memory |
| irq_i | input | NIRQ | External interrupt request lines |
| m_eret_i | input | 1 | Instruction in memory is a return-from-exception |
| kill_f_o | output | 1 | Squash the fetch stage |
| kill_d_o | output | 1 | Squash the decode stage |
| kill_e_o | output | 1 | Squash the execute stage |
| wb_kill_o | output | 1 | Block writeback of the commit instruction |
| redirect_o | output | 1 | Replace the next fetch PC |
| redirect_pc_o | output | XLEN | New fetch PC (handler or saved PC) |
| cause_o | output | 3 | Saved cause code |
| epc_o | output | XLEN | Saved PC of the trapped instruction |
| int_en_o | output | 1 | Interrupt enable |
| user_mode_o | output | 1 | 1 = user mode, 0 = kernel mode |

## Verification
Directed sequences exercise the controller in several ways:
- A single instruction is given fetch, decode, execute and memory faults together. This separates earliest-stage priority from simple OR-ing of the flags.
- The same instruction is watched in its early stages to show that no early flush occurs.
- An interrupt coincides with a data fault, once while enabled and once while masked. This tells override apart from masking.
- Bubbles are sent with every fault line high, and faults are placed on the instructions directly behind a trap. This shows that empty and discarded slots cannot trap.

A long seeded random run then mixes faults, interrupts and returns at varied rates. Every cycle is compared against a reference model, which catches back-to-back interactions such as a return colliding with a fault.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EXC_IRQ   = 3'd0,
    EXC_FETCH = 3'd1,
    EXC_ILL   = 3'd2,
    EXC_OVF   = 3'd3,
    EXC_DMEM  = 3'd4
  } cause_t;

  // Fault record carried beside each in-flight instruction
  typedef struct packed {
    logic   valid;
    logic   exc;
    cause_t cause;
  } slot_t;

  // Cause code attached by the detector that sits before stage register idx
  function automatic cause_t stage_cause(input int idx);
    case (idx)
      0:       return EXC_FETCH;
      1:       return EXC_ILL;
      default: return EXC_OVF;
    endcase
  endfunction

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int     XLEN = 32,
  parameter cause_t CODE = EXC_FETCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush_i,
  input  slot_t           in_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            fault_i,
  output slot_t           q_o,
  output logic [XLEN-1:0] pc_o
);

  slot_t nxt;

  // An older fault already recorded keeps its cause; a bubble never gains one
  always_comb begin
    nxt = in_i;
    if (in_i.valid && !in_i.exc && fault_i) begin
      nxt.exc   = 1'b1;
      nxt.cause = CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) q_o <= '0;
    else                q_o <= nxt;
  end

  always_ff @(posedge clk) begin
    pc_o <= pc_i;
  end

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NIRQ       = 4,
  parameter logic [XLEN-1:0] HANDLER_PC = '0
) (
  input  slot_t           m_i,
  input  logic            dfault_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            ie_i,
  input  logic            eret_i,
  input  logic [XLEN-1:0] epc_i,
  output logic            take_o,
  output logic            ret_o,
  output cause_t          cause_o,
  output logic [XLEN-1:0] target_o
);

  logic   inst_exc;
  logic   irq_hit;
  cause_t inst_cause;

  always_comb begin
    inst_exc   = m_i.exc || dfault_i;
    inst_cause = m_i.exc ? m_i.cause : EXC_DMEM;
    irq_hit    = ie_i && m_i.valid && (|irq_i);
    take_o     = m_i.valid && (irq_hit || inst_exc);
    cause_o    = irq_hit ? EXC_IRQ : inst_cause;
    ret_o      = m_i.valid && eret_i && !take_o;
    target_o   = take_o ? HANDLER_PC : epc_i;
  end

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic            ret_i,
  input  cause_t          cause_i,
  input  logic [XLEN-1:0] pc_i,
  output cause_t          cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic            ie_o,
  output logic            user_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_o <= EXC_IRQ;
      epc_o   <= '0;
      ie_o    <= 1'b0;
      user_o  <= 1'b0;
    end else if (take_i) begin
      cause_o <= cause_i;
      epc_o   <= pc_i;
      ie_o    <= 1'b0;
      user_o  <= 1'b0;
    end else if (ret_i) begin
      ie_o    <= 1'b1;
      user_o  <= 1'b1;
    end
  end

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NIRQ       = 4,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            f_valid_i,
  input  logic [XLEN-1:0] f_pc_i,
  input  logic            f_addr_fault_i,
  input  logic            d_illegal_i,
  input  logic            e_overflow_i,
  input  logic            m_addr_fault_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            m_eret_i,
  output logic            kill_f_o,
  output logic            kill_d_o,
  output logic            kill_e_o,
  output logic            wb_kill_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [2:0]      cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic            int_en_o,
  output logic            user_mode_o
);

  localparam int NSTG = 3;  // stage registers: decode, execute, memory

  slot_t           slot [NSTG+1];
  logic [XLEN-1:0] pcs  [NSTG+1];
  logic [NSTG-1:0] faults;
  logic            take, ret, flush;
  cause_t          take_cause, cause_q;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] m_pc;

  always_comb begin
    slot[0].valid = f_valid_i;
    slot[0].exc   = 1'b0;
    slot[0].cause = EXC_IRQ;
  end
  assign pcs[0] = f_pc_i;
  assign faults = {e_overflow_i, d_illegal_i, f_addr_fault_i};

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
      exc_stage_reg #(
        .XLEN (XLEN),
        .CODE (stage_cause(g))
      ) u_stage (
        .clk     (clk),
        .rst     (rst),
        .flush_i (flush),
        .in_i    (slot[g]),
        .pc_i    (pcs[g]),
        .fault_i (faults[g]),
        .q_o     (slot[g+1]),
        .pc_o    (pcs[g+1])
      );
    end
  endgenerate

  assign m_pc = pcs[NSTG];

  exc_commit_unit #(
    .XLEN       (XLEN),
    .NIRQ       (NIRQ),
    .HANDLER_PC (HANDLER_PC)
  ) u_commit (
    .m_i      (slot[NSTG]),
    .dfault_i (m_addr_fault_i),
    .irq_i    (irq_i),
    .ie_i     (int_en_o),
    .eret_i   (m_eret_i),
    .epc_i    (epc_o),
    .take_o   (take),
    .ret_o    (ret),
    .cause_o  (take_cause),
    .target_o (target)
  );

  exc_status_regs #(
    .XLEN (XLEN)
  ) u_status (
    .clk     (clk),
    .rst     (rst),
    .take_i  (take),
    .ret_i   (ret),
    .cause_i (take_cause),
    .pc_i    (m_pc),
    .cause_o (cause_q),
    .epc_o   (epc_o),
    .ie_o    (int_en_o),
    .user_o  (user_mode_o)
  );

  assign flush         = take || ret;
  assign kill_f_o      = flush;
  assign kill_d_o      = flush;
  assign kill_e_o      = flush;
  assign wb_kill_o     = take;
  assign redirect_o    = flush;
  assign redirect_pc_o = target;
  assign cause_o       = cause_q;

endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NIRQ       = 4,
  parameter logic [XLEN-1:0] HANDLER_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [NIRQ-1:0] irq_i,
  input logic            kill_f_o,
  input logic            kill_d_o,
  input logic            kill_e_o,
  input logic            wb_kill_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [2:0]      cause_o,
  input logic [XLEN-1:0] epc_o,
  input logic            int_en_o,
  input logic            user_mode_o,
  input logic [XLEN-1:0] m_pc_i
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cause_o == 3'd0 && epc_o == '0 && !int_en_o && !user_mode_o && !redirect_o));

  a_r5_trap_flush: assert property (@(posedge clk) disable iff (rst)
    wb_kill_o |-> (kill_f_o && kill_d_o && kill_e_o && redirect_o && redirect_pc_o == HANDLER_PC));

  a_r6_epc_capture: assert property (@(posedge clk) disable iff (rst)
    wb_kill_o |=> (epc_o == $past(m_pc_i)));

  a_r6_epc_hold: assert property (@(posedge clk) disable iff (rst)
    !wb_kill_o |=> $stable(epc_o));

  a_r7_mask_on_entry: assert property (@(posedge clk) disable iff (rst)
    wb_kill_o |=> (!int_en_o && !user_mode_o));

  a_r8_return_target: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && !wb_kill_o) |-> (redirect_pc_o == epc_o && kill_f_o && kill_d_o && kill_e_o));

  a_r8_return_unmask: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && !wb_kill_o) |=> (int_en_o && user_mode_o));

  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    kill_e_o |=> !redirect_o);

  a_r4_irq_override: assert property (@(posedge clk) disable iff (rst)
    (wb_kill_o && int_en_o && (|irq_i)) |=> (cause_o == 3'd0));

  a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (wb_kill_o && !int_en_o) |=> (cause_o != 3'd0));

  a_r10_cause_range: assert property (@(posedge clk) disable iff (rst)
    cause_o <= 3'd4);

endmodule

bind exc_commit_ctrl exc_commit_chk #(
  .XLEN       (XLEN),
  .NIRQ       (NIRQ),
  .HANDLER_PC (HANDLER_PC)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .irq_i         (irq_i),
  .kill_f_o      (kill_f_o),
  .kill_d_o      (kill_d_o),
  .kill_e_o      (kill_e_o),
  .wb_kill_o     (wb_kill_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .cause_o       (cause_o),
  .epc_o         (epc_o),
  .int_en_o      (int_en_o),
  .user_mode_o   (user_mode_o),
  .m_pc_i        (m_pc)
);

// File: tb/test_exc_commit_ctrl.sv
module test_exc_commit_ctrl;

  localparam int          XLEN = 32;
  localparam int          NIRQ = 4;
  localparam logic [31:0] HPC  = 32'h0000_0180;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            f_valid_i = 1'b0;
  logic [XLEN-1:0] f_pc_i = '0;
  logic            f_addr_fault_i = 1'b0, d_illegal_i = 1'b0, e_overflow_i = 1'b0, m_addr_fault_i = 1'b0;
  logic [NIRQ-1:0] irq_i = '0;
  logic            m_eret_i = 1'b0;
  logic            kill_f_o, kill_d_o, kill_e_o, wb_kill_o, redirect_o;
  logic [XLEN-1:0] redirect_pc_o, epc_o;
  logic [2:0]      cause_o;
  logic            int_en_o, user_mode_o;

  always #2 clk = ~clk;

  exc_commit_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ), .HANDLER_PC(HPC)) i_exc_commit_ctrl (
    .clk(clk), .rst(rst), .f_valid_i(f_valid_i), .f_pc_i(f_pc_i),
    .f_addr_fault_i(f_addr_fault_i), .d_illegal_i(d_illegal_i),
    .e_overflow_i(e_overflow_i), .m_addr_fault_i(m_addr_fault_i),
    .irq_i(irq_i), .m_eret_i(m_eret_i),
    .kill_f_o(kill_f_o), .kill_d_o(kill_d_o), .kill_e_o(kill_e_o),
    .wb_kill_o(wb_kill_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .cause_o(cause_o), .epc_o(epc_o), .int_en_o(int_en_o), .user_mode_o(user_mode_o)
  );

  int checks = 0;
  int errors = 0;

  // Reference model: index 0 = decode, 1 = execute, 2 = memory
  logic        mv [3];
  logic        mx [3];
  int          mc [3];
  logic [31:0] mp [3];
  int          e_cause = 0;
  logic [31:0] e_epc = '0;
  logic        e_ie = 1'b0, e_user = 1'b0;
  logic        obs_redirect = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int merge_cause(input logic oldx, input int oldc, input logic fault, input int code);
    return oldx ? oldc : (fault ? code : oldc);
  endfunction

  // One cycle: drive at edge+1, compare combinational outputs at edge+3,
  // then advance the model and compare the registered state at next edge+1.
  task automatic cyc(input logic fv, input logic [31:0] pc, input logic pcf, input logic ill,
                     input logic ovf, input logic dfa, input logic [NIRQ-1:0] irq, input logic er);
    logic take, ret, iexc, irqhit;
    int   icause, ncause;
    f_valid_i = fv; f_pc_i = pc; f_addr_fault_i = pcf; d_illegal_i = ill;
    e_overflow_i = ovf; m_addr_fault_i = dfa; irq_i = irq; m_eret_i = er;
    #2;
    iexc   = mv[2] && (mx[2] || dfa);
    icause = mx[2] ? mc[2] : 4;
    irqhit = e_ie && mv[2] && (irq != '0);
    take   = mv[2] && (irqhit || iexc);
    ret    = mv[2] && er && !take;
    ncause = irqhit ? 0 : icause;
    chk("R5 redirect", redirect_o, take || ret);
    chk("R5 wb_kill", wb_kill_o, take);
    chk("R5 kill_f", kill_f_o, take || ret);
    chk("R5 kill_d", kill_d_o, take || ret);
    chk("R5 kill_e", kill_e_o, take || ret);
    if (take)     chk("R5 handler pc", redirect_pc_o, HPC);
    else if (ret) chk("R8 return pc", redirect_pc_o, e_epc);
    obs_redirect = redirect_o;
    @(posedge clk);
    #1;
    if (take) begin
      e_cause = ncause; e_epc = mp[2]; e_ie = 1'b0; e_user = 1'b0;
    end else if (ret) begin
      e_ie = 1'b1; e_user = 1'b1;
    end
    if (take || ret) begin
      for (int i = 0; i < 3; i++) begin mv[i] = 1'b0; mx[i] = 1'b0; end
    end else begin
      mv[2] = mv[1]; mc[2] = merge_cause(mx[1], mc[1], mv[1] && ovf, 3);
      mx[2] = mx[1] || (mv[1] && ovf); mp[2] = mp[1];
      mv[1] = mv[0]; mc[1] = merge_cause(mx[0], mc[0], mv[0] && ill, 2);
      mx[1] = mx[0] || (mv[0] && ill); mp[1] = mp[0];
      mv[0] = fv; mx[0] = fv && pcf; mc[0] = 1; mp[0] = pc;
    end
    chk("R10 cause", cause_o, e_cause);
    chk("R6 epc", epc_o, e_epc);
    chk("R7 int_en", int_en_o, e_ie);
    chk("R7 user_mode", user_mode_o, e_user);
  endtask

  task automatic nop(input logic [31:0] pc);
    cyc(1'b1, pc, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic do_return(input logic [31:0] pc);
    nop(pc); nop(pc + 4); nop(pc + 8);
    cyc(1'b1, pc + 12, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin mv[i] = 1'b0; mx[i] = 1'b0; mc[i] = 0; mp[i] = '0; end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1: reset values
    chk("R1 cause", cause_o, 0);
    chk("R1 epc", epc_o, 0);
    chk("R1 int_en", int_en_o, 0);
    chk("R1 user_mode", user_mode_o, 0);
    chk("R1 redirect", redirect_o, 0);
    @(posedge clk); #1;

    // R3: one instruction with faults in every stage keeps the fetch cause
    cyc(1'b1, 32'h100, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    cyc(1'b1, 32'h104, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    chk("R2 no early flush (decode)", obs_redirect, 0);
    cyc(1'b1, 32'h108, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    chk("R2 no early flush (execute)", obs_redirect, 0);
    // trap cycle; younger instructions get faults too
    cyc(1'b1, 32'h10c, 1'b0, 1'b1, 1'b1, 1'b1, '0, 1'b0);
    chk("R3 earliest cause wins", cause_o, 1);
    chk("R6 epc of trapped instruction", epc_o, 32'h100);
    // R9 / R12: bubbles with every fault high
    cyc(1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0);
    chk("R9 younger discarded", obs_redirect, 0);
    cyc(1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0);
    chk("R12 bubble fault ignored", obs_redirect, 0);
    cyc(1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0);
    chk("R12 bubble fault ignored", obs_redirect, 0);

    // R8: return
    do_return(32'h200);
    chk("R8 return redirect", obs_redirect, 1);
    chk("R8 int_en set", int_en_o, 1);
    chk("R8 user_mode set", user_mode_o, 1);

    // R4: enabled interrupt overrides a data fault
    nop(32'h400); nop(32'h404); nop(32'h408);
    cyc(1'b1, 32'h40c, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0010, 1'b0);
    chk("R4 interrupt cause", cause_o, 0);
    chk("R4 epc", epc_o, 32'h400);

    // R11: masked interrupt with a clean instruction, then with a data fault
    cyc(1'b1, 32'h500, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111, 1'b0);
    cyc(1'b1, 32'h504, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111, 1'b0);
    cyc(1'b1, 32'h508, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111, 1'b0);
    cyc(1'b1, 32'h50c, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1111, 1'b0);
    chk("R11 masked irq no trap", obs_redirect, 0);
    cyc(1'b1, 32'h510, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1000, 1'b0);
    chk("R11 masked irq keeps own cause", cause_o, 4);

    // R10: overflow alone gives cause 3; a faulting return traps instead (R8)
    cyc(1'b1, 32'h600, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    nop(32'h604);
    cyc(1'b1, 32'h608, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    cyc(1'b1, 32'h60c, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    chk("R10 overflow cause", cause_o, 3);
    chk("R8 trap beats return", int_en_o, 0);

    // Seeded random mix
    for (int n = 0; n < 5000; n++) begin
      logic [31:0] rpc;
      rpc = {$urandom() % 32'h0001_0000, 2'b00};
      cyc(($urandom() % 10) < 8, rpc,
          ($urandom() % 20) == 0, ($urandom() % 20) == 0,
          ($urandom() % 20) == 0, ($urandom() % 20) == 0,
          (($urandom() % 16) == 0) ? NIRQ'($urandom()) : '0,
          ($urandom() % 12) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule